// File: doc/BRIEF.md
# Paged Call/Return Control Unit

This block is the program-flow unit of a small 8-bit processor core. It owns the 16-bit program counter, the 16-bit stack pointer and a page register that selects the window of expanded memory. It carries out six flow operations: jump, relative branch-to-subroutine, jump-to-subroutine, paged call, return-from-subroutine and return-from-call. Stack traffic goes over a single-port byte-wide data-memory port, and that port makes one access per clock.

The decoder presents an operation code together with operands that are already resolved: a target address or pointer, an immediate page value and the address of the following instruction. It then pulses `start` while the unit is idle. The unit raises `busy` while it runs the operation. It pulses `done` for one cycle in the first idle cycle, and in that cycle the new PC, SP and page values are visible. In indirect mode the target address, and for a paged call also the new page value, are read from memory through a pointer before any stacking begins. A parameter can remove expanded addressing. The page register then stays at zero, but paged calls and returns still move a page byte so that the stack frame keeps the same shape.

Top module: `callret_unit`

## Requirements
- R1: After reset, pc equals RESET_PC, sp equals RESET_SP, page is zero, and busy and done are low.
- R2: Jump (opCode 0) loads pc with the target and leaves sp, page and memory untouched.
- R3: Branch-to-subroutine (opCode 1) uses operandAddr[7:0] as a signed displacement added to nextPc to form the target. It stacks the return address as R4 describes.
- R4: Jump-to-subroutine (opCode 2) and branch-to-subroutine lower sp by 2, write nextPc[15:8] at the new sp and nextPc[7:0] at new sp+1, then load pc with the target.
- R5: Paged call (opCode 3) stacks the return address as in R4, then lowers sp by 1 more and writes the old page at the new sp. It then loads page with the new page value and pc with the target.
- R6: Return-from-subroutine (opCode 4) loads pc[15:8] from sp and pc[7:0] from sp+1, then raises sp by 2.
- R7: Return-from-call (opCode 5) loads page from sp and raises sp by 1. It then loads pc from sp (high) and sp+1 (low) and raises sp by 2, for a net change of +3.
- R8: With indirect set, jump, jump-to-subroutine and paged call read the target high byte at the pointer (operandAddr) and the low byte at pointer+1. A paged call also reads the new page at pointer+2, and operandPage is then ignored.
- R9: Each memory access takes one clock. busy lasts 1 cycle for a direct jump and 3 for an indirect jump, 3 for jump-to-subroutine, branch-to-subroutine or return-from-subroutine, 4 for a direct paged call or a return-from-call, and 5 for an indirect jump-to-subroutine and 7 for an indirect paged call. done pulses in the first cycle after busy falls.
- R10: sp arithmetic and stack addresses wrap modulo 2^16.
- R11: With EXPANDED=0 the page stays zero through call and return, while the page byte is still written and read on the stack.
- R12: start is ignored while busy is high, and no memory write occurs while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| opCode | input | 3 | 0 jump, 1 branch-sub, 2 jump-sub, 3 paged call, 4 return-sub, 5 return-call |
| indirect | input | 1 | Fetch the target (and page) through the pointer in operandAddr |
| operandAddr | input | 16 | Target address, pointer, or displacement in bits 7:0 |
| operandPage | input | PAGE_W | Immediate page value for a paged call |
| nextPc | input | 16 | Address of the following instruction |
| memAddr | output | 16 | Data-memory byte address |
| memWe | output | 1 | Write strobe for this cycle |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data for memAddr, same cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| page | output | PAGE_W | Expanded-memory page register |

## Verification
The assertions check on every cycle that an idle unit never writes memory and that a jump never writes. They also check that each operation leaves sp displaced by its fixed net amount, that done follows the fall of busy as a single pulse, and that the page stays at zero in the flat variant. Only the bench scenarios can show where each byte lands and in what order it is written, the values recovered by returns, indirect operand fetches, displacement arithmetic, the exact cycle counts and the wrap of the stack across address zero.

// File: rtl/callret_pkg.sv
package callret_pkg;

  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_JMP  = 3'd0,
    OP_BSR  = 3'd1,
    OP_JSR  = 3'd2,
    OP_CALL = 3'd3,
    OP_RTS  = 3'd4,
    OP_RTC  = 3'd5
  } flowOp_e;

  // Which byte access the datapath performs this cycle.
  typedef enum logic [3:0] {
    MEM_IDLE      = 4'd0,
    MEM_RD_PTR_H  = 4'd1,
    MEM_RD_PTR_L  = 4'd2,
    MEM_RD_PTR_PG = 4'd3,
    MEM_WR_RET_H  = 4'd4,
    MEM_WR_RET_L  = 4'd5,
    MEM_WR_PAGE   = 4'd6,
    MEM_RD_PAGE   = 4'd7,
    MEM_RD_RET_H  = 4'd8,
    MEM_RD_RET_L  = 4'd9
  } memStep_e;

  typedef struct packed {
    logic     latchOps;
    logic     relTarget;
    memStep_e memStep;
    logic     spDec2;
    logic     spDec1;
    logic     spInc1;
    logic     spInc2;
    logic     pcFromTarget;
    logic     pcFromStack;
    logic     pageFromNew;
    logic     pageFromStack;
  } flowStrobes_t;

endpackage

// File: rtl/callret_ctrl.sv
module callret_ctrl
  import callret_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [2:0]   opCode,
  input  logic         indirect,
  output flowStrobes_t strb,
  output logic         busy,
  output logic         done
);

  typedef enum logic [3:0] {
    S_IDLE, S_RD_H, S_RD_L, S_RD_PG,
    S_PUSH_H, S_PUSH_L, S_PUSH_PG,
    S_POP_PG, S_POP_H, S_POP_L, S_FINISH
  } state_e;

  state_e  stQ, stD;
  flowOp_e opQ;
  flowOp_e opIn;
  logic    legal;
  logic    doneQ;

  assign opIn  = flowOp_e'(opCode);
  assign legal = (opCode <= 3'd5);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ   <= S_IDLE;
      opQ   <= OP_JMP;
      doneQ <= 1'b0;
    end else begin
      stQ   <= stD;
      doneQ <= (stQ == S_FINISH);
      if (strb.latchOps) opQ <= opIn;
    end
  end

  always_comb begin
    strb = '0;
    stD  = stQ;
    unique case (stQ)
      S_IDLE: begin
        if (start && legal) begin
          strb.latchOps  = 1'b1;
          strb.relTarget = (opIn == OP_BSR);
          case (opIn)
            OP_JMP:  stD = indirect ? S_RD_H : S_FINISH;
            OP_BSR:  stD = S_PUSH_H;
            OP_JSR,
            OP_CALL: stD = indirect ? S_RD_H : S_PUSH_H;
            OP_RTS:  stD = S_POP_H;
            OP_RTC:  stD = S_POP_PG;
            default: stD = S_IDLE;
          endcase
        end
      end
      S_RD_H: begin
        strb.memStep = MEM_RD_PTR_H;
        stD = S_RD_L;
      end
      S_RD_L: begin
        strb.memStep = MEM_RD_PTR_L;
        if (opQ == OP_CALL)     stD = S_RD_PG;
        else if (opQ == OP_JMP) stD = S_FINISH;
        else                    stD = S_PUSH_H;
      end
      S_RD_PG: begin
        strb.memStep = MEM_RD_PTR_PG;
        stD = S_PUSH_H;
      end
      S_PUSH_H: begin
        strb.memStep = MEM_WR_RET_H;
        stD = S_PUSH_L;
      end
      S_PUSH_L: begin
        strb.memStep = MEM_WR_RET_L;
        strb.spDec2  = 1'b1;
        stD = (opQ == OP_CALL) ? S_PUSH_PG : S_FINISH;
      end
      S_PUSH_PG: begin
        strb.memStep = MEM_WR_PAGE;
        strb.spDec1  = 1'b1;
        stD = S_FINISH;
      end
      S_POP_PG: begin
        strb.memStep = MEM_RD_PAGE;
        strb.spInc1  = 1'b1;
        stD = S_POP_H;
      end
      S_POP_H: begin
        strb.memStep = MEM_RD_RET_H;
        stD = S_POP_L;
      end
      S_POP_L: begin
        strb.memStep = MEM_RD_RET_L;
        strb.spInc2  = 1'b1;
        stD = S_FINISH;
      end
      S_FINISH: begin
        case (opQ)
          OP_RTS: strb.pcFromStack = 1'b1;
          OP_RTC: begin
            strb.pcFromStack   = 1'b1;
            strb.pageFromStack = 1'b1;
          end
          OP_CALL: begin
            strb.pcFromTarget = 1'b1;
            strb.pageFromNew  = 1'b1;
          end
          default: strb.pcFromTarget = 1'b1;
        endcase
        stD = S_IDLE;
      end
      default: stD = S_IDLE;
    endcase
  end

  assign busy = (stQ != S_IDLE);
  assign done = doneQ;

endmodule

// File: rtl/callret_dpath.sv
module callret_dpath
  import callret_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h8000,
  parameter logic [ADDR_W-1:0] RESET_SP = 16'h2000,
  parameter int                PAGE_W   = 8,
  parameter bit                EXPANDED = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  flowStrobes_t        strb,
  input  logic [ADDR_W-1:0]   operandAddr,
  input  logic [PAGE_W-1:0]   operandPage,
  input  logic [ADDR_W-1:0]   nextPc,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memWe,
  output logic [BYTE_W-1:0]   memWdata,
  input  logic [BYTE_W-1:0]   memRdata,
  output logic [ADDR_W-1:0]   pc,
  output logic [ADDR_W-1:0]   sp,
  output logic [PAGE_W-1:0]   page
);

  localparam int HALF_W = ADDR_W / 2;

  logic [ADDR_W-1:0] pcQ, spQ, tgtQ, ptrQ, retQ, popRetQ;
  logic [PAGE_W-1:0] pageQ, newPageQ, popPageQ;
  logic [ADDR_W-1:0] relTgt;

  assign relTgt = nextPc + {{(ADDR_W-BYTE_W){operandAddr[BYTE_W-1]}}, operandAddr[BYTE_W-1:0]};

  // Byte access decode: one access per cycle.
  always_comb begin
    memAddr  = spQ;
    memWe    = 1'b0;
    memWdata = '0;
    unique case (strb.memStep)
      MEM_RD_PTR_H:  memAddr = ptrQ;
      MEM_RD_PTR_L:  memAddr = ptrQ + ADDR_W'(1);
      MEM_RD_PTR_PG: memAddr = ptrQ + ADDR_W'(2);
      MEM_WR_RET_H: begin
        memAddr  = spQ - ADDR_W'(2);
        memWe    = 1'b1;
        memWdata = retQ[ADDR_W-1:HALF_W];
      end
      MEM_WR_RET_L: begin
        memAddr  = spQ - ADDR_W'(1);
        memWe    = 1'b1;
        memWdata = retQ[HALF_W-1:0];
      end
      MEM_WR_PAGE: begin
        memAddr  = spQ - ADDR_W'(1);
        memWe    = 1'b1;
        memWdata = BYTE_W'(pageQ);
      end
      MEM_RD_PAGE:   memAddr = spQ;
      MEM_RD_RET_H:  memAddr = spQ;
      MEM_RD_RET_L:  memAddr = spQ + ADDR_W'(1);
      default:       memAddr = spQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
      retQ <= '0;
    end else if (strb.latchOps) begin
      ptrQ <= operandAddr;
      retQ <= nextPc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tgtQ <= '0;
    else if (strb.latchOps) tgtQ <= strb.relTarget ? relTgt : operandAddr;
    else if (strb.memStep == MEM_RD_PTR_H) tgtQ[ADDR_W-1:HALF_W] <= memRdata;
    else if (strb.memStep == MEM_RD_PTR_L) tgtQ[HALF_W-1:0] <= memRdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) newPageQ <= '0;
    else if (strb.latchOps) newPageQ <= operandPage;
    else if (strb.memStep == MEM_RD_PTR_PG) newPageQ <= PAGE_W'(memRdata);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      popRetQ  <= '0;
      popPageQ <= '0;
    end else begin
      if (strb.memStep == MEM_RD_RET_H) popRetQ[ADDR_W-1:HALF_W] <= memRdata;
      if (strb.memStep == MEM_RD_RET_L) popRetQ[HALF_W-1:0] <= memRdata;
      if (strb.memStep == MEM_RD_PAGE)  popPageQ <= PAGE_W'(memRdata);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) spQ <= RESET_SP;
    else if (strb.spDec2) spQ <= spQ - ADDR_W'(2);
    else if (strb.spDec1) spQ <= spQ - ADDR_W'(1);
    else if (strb.spInc1) spQ <= spQ + ADDR_W'(1);
    else if (strb.spInc2) spQ <= spQ + ADDR_W'(2);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcQ <= RESET_PC;
    else if (strb.pcFromTarget) pcQ <= tgtQ;
    else if (strb.pcFromStack)  pcQ <= popRetQ;
  end

  generate
    if (EXPANDED) begin : g_paged
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pageQ <= '0;
        else if (strb.pageFromNew)   pageQ <= newPageQ;
        else if (strb.pageFromStack) pageQ <= popPageQ;
      end
    end else begin : g_flat
      assign pageQ = '0;
    end
  endgenerate

  assign pc   = pcQ;
  assign sp   = spQ;
  assign page = pageQ;

endmodule

// File: rtl/callret_unit.sv
module callret_unit
  import callret_pkg::*;
#(
  parameter logic [15:0] RESET_PC = 16'h8000,
  parameter logic [15:0] RESET_SP = 16'h2000,
  parameter int          PAGE_W   = 8,
  parameter bit          EXPANDED = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        opCode,
  input  logic              indirect,
  input  logic [15:0]       operandAddr,
  input  logic [PAGE_W-1:0] operandPage,
  input  logic [15:0]       nextPc,
  output logic [15:0]       memAddr,
  output logic              memWe,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  output logic              busy,
  output logic              done,
  output logic [15:0]       pc,
  output logic [15:0]       sp,
  output logic [PAGE_W-1:0] page
);

  flowStrobes_t strb;

  callret_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opCode   (opCode),
    .indirect (indirect),
    .strb     (strb),
    .busy     (busy),
    .done     (done)
  );

  callret_dpath #(
    .RESET_PC (RESET_PC),
    .RESET_SP (RESET_SP),
    .PAGE_W   (PAGE_W),
    .EXPANDED (EXPANDED)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .operandAddr (operandAddr),
    .operandPage (operandPage),
    .nextPc      (nextPc),
    .memAddr     (memAddr),
    .memWe       (memWe),
    .memWdata    (memWdata),
    .memRdata    (memRdata),
    .pc          (pc),
    .sp          (sp),
    .page        (page)
  );

endmodule

// File: rtl/callret_checker.sv
module callret_checker #(
  parameter int PAGE_W   = 8,
  parameter bit EXPANDED = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [2:0]        opCode,
  input logic              busy,
  input logic              done,
  input logic              memWe,
  input logic [15:0]       sp,
  input logic [PAGE_W-1:0] page
);

  logic [2:0]        curOp;
  logic [15:0]       spAt;
  logic [PAGE_W-1:0] pageAt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curOp  <= '0;
      spAt   <= '0;
      pageAt <= '0;
    end else if (start && !busy && opCode <= 3'd5) begin
      curOp  <= opCode;
      spAt   <= sp;
      pageAt <= page;
    end
  end

  a_r12_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memWe);

  a_r2_jmp_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (busy && curOp == 3'd0) |-> !memWe);

  a_r2_jmp_keeps_state: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && curOp == 3'd0) |-> (sp == spAt && page == pageAt));

  a_r4_sub_sp_step: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && (curOp == 3'd1 || curOp == 3'd2)) |-> (sp == 16'(spAt - 16'd2)));

  a_r5_call_sp_step: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && curOp == 3'd3) |-> (sp == 16'(spAt - 16'd3)));

  a_r6_rts_sp_step: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && curOp == 3'd4) |-> (sp == 16'(spAt + 16'd2)));

  a_r7_rtc_sp_step: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && curOp == 3'd5) |-> (sp == 16'(spAt + 16'd3)));

  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r11_flat_page: assert property (@(posedge clk) disable iff (!rstN)
    (EXPANDED == 1'b0) |-> (page == '0));

endmodule

bind callret_unit callret_checker #(
  .PAGE_W   (PAGE_W),
  .EXPANDED (EXPANDED)
) u_callretChk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .opCode (opCode),
  .busy   (busy),
  .done   (done),
  .memWe  (memWe),
  .sp     (sp),
  .page   (page)
);

// File: tb/callret_unit_bench.sv
module callret_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, startF = 1'b0;
  logic [2:0]  opCode = '0;
  logic        indirect = 1'b0;
  logic [15:0] operandAddr = '0;
  logic [7:0]  operandPage = '0;
  logic [15:0] nextPc = '0;

  logic [15:0] memAddr, memAddrF, pc, pcF, sp, spF;
  logic        memWe, memWeF, busy, busyF, done, doneF;
  logic [7:0]  memWdata, memWdataF, memRdata, memRdataF, page, pageF;

  logic [7:0] mem  [0:65535];
  logic [7:0] memF [0:65535];

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  always @(posedge clk) if (memWe)  mem[memAddr]   <= memWdata;
  always @(posedge clk) if (memWeF) memF[memAddrF] <= memWdataF;
  assign memRdata  = mem[memAddr];
  assign memRdataF = memF[memAddrF];

  callret_unit u_callret_unit (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode), .indirect(indirect),
    .operandAddr(operandAddr), .operandPage(operandPage), .nextPc(nextPc),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata),
    .busy(busy), .done(done), .pc(pc), .sp(sp), .page(page)
  );

  callret_unit #(.RESET_SP(16'h0001), .EXPANDED(1'b0)) u_callret_unit_flat (
    .clk(clk), .rstN(rstN), .start(startF), .opCode(opCode), .indirect(indirect),
    .operandAddr(operandAddr), .operandPage(operandPage), .nextPc(nextPc),
    .memAddr(memAddrF), .memWe(memWeF), .memWdata(memWdataF), .memRdata(memRdataF),
    .busy(busyF), .done(doneF), .pc(pcF), .sp(spF), .page(pageF)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic        ind;
    logic [15:0] tgt;
    logic [7:0]  pg;
    logic [15:0] np;
    logic [15:0] ePc;
    logic [15:0] eSp;
    logic [7:0]  ePg;
    logic [3:0]  eCyc;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{3'd0, 1'b0, 16'h1234, 8'h00, 16'h0000, 16'h1234, 16'h2000, 8'h00, 4'd1},
    '{3'd2, 1'b0, 16'h4000, 8'h00, 16'h1237, 16'h4000, 16'h1FFE, 8'h00, 4'd3},
    '{3'd1, 1'b0, 16'h00F0, 8'h00, 16'h4002, 16'h3FF2, 16'h1FFC, 8'h00, 4'd3},
    '{3'd3, 1'b0, 16'h9000, 8'h05, 16'h3FF6, 16'h9000, 16'h1FF9, 8'h05, 4'd4},
    '{3'd3, 1'b1, 16'h0100, 8'hEE, 16'h9004, 16'hA1B2, 16'h1FF6, 8'h07, 4'd7},
    '{3'd5, 1'b0, 16'h0000, 8'h00, 16'h0000, 16'h9004, 16'h1FF9, 8'h05, 4'd4},
    '{3'd5, 1'b0, 16'h0000, 8'h00, 16'h0000, 16'h3FF6, 16'h1FFC, 8'h00, 4'd4},
    '{3'd4, 1'b0, 16'h0000, 8'h00, 16'h0000, 16'h4002, 16'h1FFE, 8'h00, 4'd3},
    '{3'd2, 1'b1, 16'h0200, 8'h00, 16'h4005, 16'h5AC3, 16'h1FFC, 8'h00, 4'd5},
    '{3'd4, 1'b0, 16'h0000, 8'h00, 16'h0000, 16'h4005, 16'h1FFE, 8'h00, 4'd3},
    '{3'd4, 1'b0, 16'h0000, 8'h00, 16'h0000, 16'h1237, 16'h2000, 8'h00, 4'd3},
    '{3'd0, 1'b1, 16'h0300, 8'h00, 16'h0000, 16'h7788, 16'h2000, 8'h00, 4'd3},
    '{3'd1, 1'b0, 16'h007F, 8'h00, 16'h7790, 16'h780F, 16'h1FFE, 8'h00, 4'd3},
    '{3'd4, 1'b0, 16'h0000, 8'h00, 16'h0000, 16'h7790, 16'h2000, 8'h00, 4'd3}
  };

  function automatic string reqOf(logic [2:0] op, logic ind);
    if (ind) return "R8";
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one operation; returns number of busy cycles and done seen after.
  task automatic runOp(bit flat, logic [2:0] op, logic ind, logic [15:0] tgt,
                       logic [7:0] pg, logic [15:0] np, output int cyc, output logic dn);
    @(negedge clk);
    opCode = op; indirect = ind; operandAddr = tgt; operandPage = pg; nextPc = np;
    if (flat) startF = 1'b1; else start = 1'b1;
    @(negedge clk);
    startF = 1'b0; start = 1'b0;
    cyc = 0;
    while ((flat ? busyF : busy) && cyc < 40) begin
      cyc++;
      @(negedge clk);
    end
    dn = flat ? doneF : done;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int   cyc;
    logic dn;
    mem[16'h0100] = 8'hA1; mem[16'h0101] = 8'hB2; mem[16'h0102] = 8'h07;
    mem[16'h0200] = 8'h5A; mem[16'h0201] = 8'hC3;
    mem[16'h0300] = 8'h77; mem[16'h0301] = 8'h88;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pc",   32'(pc),   32'h8000);
    chk("R1 sp",   32'(sp),   32'h2000);
    chk("R1 page", 32'(page), 32'h00);
    chk("R1 busy", 32'(busy), 32'h0);
    chk("R1 done", 32'(done), 32'h0);
    chk("R1 flat sp", 32'(spF), 32'h0001);

    for (int i = 0; i < NVEC; i++) begin
      runOp(1'b0, VECS[i].op, VECS[i].ind, VECS[i].tgt, VECS[i].pg, VECS[i].np, cyc, dn);
      chk(reqOf(VECS[i].op, VECS[i].ind), 32'(pc),   32'(VECS[i].ePc));
      chk(reqOf(VECS[i].op, VECS[i].ind), 32'(sp),   32'(VECS[i].eSp));
      chk(reqOf(VECS[i].op, VECS[i].ind), 32'(page), 32'(VECS[i].ePg));
      chk("R9 busy cycles", 32'(cyc), 32'(VECS[i].eCyc));
      chk("R9 done pulse",  32'(dn),  32'h1);
    end

    // Stack contents left behind by the sequence above
    chk("R5 page byte first call",  32'(mem[16'h1FF9]), 32'h00);
    chk("R5 page byte second call", 32'(mem[16'h1FF6]), 32'h05);
    chk("R5 ret high",              32'(mem[16'h1FF7]), 32'h90);
    chk("R5 ret low",               32'(mem[16'h1FF8]), 32'h04);
    chk("R4 ret high",              32'(mem[16'h1FFC]), 32'h40);
    chk("R4 ret low",               32'(mem[16'h1FFD]), 32'h05);
    chk("R3 ret high",              32'(mem[16'h1FFE]), 32'h77);
    chk("R3 ret low",               32'(mem[16'h1FFF]), 32'h90);
    chk("R2 jump left pointer data", 32'(mem[16'h0300]), 32'h77);

    // R12: a second start during busy is ignored
    @(negedge clk);
    opCode = 3'd2; indirect = 1'b0; operandAddr = 16'h6000; nextPc = 16'h7795;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    opCode = 3'd0; operandAddr = 16'hDEAD;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 40) begin cyc++; @(negedge clk); end
    repeat (2) @(negedge clk);
    chk("R12 pc", 32'(pc), 32'h6000);
    chk("R12 sp", 32'(sp), 32'h1FFE);
    chk("R12 stacked low", 32'(mem[16'h1FFF]), 32'h95);

    // R10/R11: flat variant, stack crossing address zero
    runOp(1'b1, 3'd3, 1'b0, 16'h5000, 8'h09, 16'h8003, cyc, dn);
    chk("R10 flat call sp",   32'(spF),   32'hFFFE);
    chk("R11 flat call page", 32'(pageF), 32'h00);
    chk("R10 flat call pc",   32'(pcF),   32'h5000);
    chk("R10 ret high at FFFF", 32'(memF[16'hFFFF]), 32'h80);
    chk("R10 ret low at 0000",  32'(memF[16'h0000]), 32'h03);
    chk("R11 page byte stacked", 32'(memF[16'hFFFE]), 32'h00);
    chk("R11 flat call cycles", 32'(cyc), 32'd4);
    runOp(1'b1, 3'd5, 1'b0, 16'h0000, 8'h00, 16'h0000, cyc, dn);
    chk("R10 flat return sp",   32'(spF),   32'h0001);
    chk("R10 flat return pc",   32'(pcF),   32'h8003);
    chk("R11 flat return page", 32'(pageF), 32'h00);
    chk("R11 flat return cycles", 32'(cyc), 32'd4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule